// File: doc/BRIEF.md
# DMA Channel Fault Tracker

This block keeps the error state of a multi-channel DMA controller, four channels by default. It checks every transfer start for source and destination addresses that do not fit the programmed transfer width. It also takes single-cycle fault pulses from the bus side: timeout, slave error and peripheral parity error. Each bus-side pulse is tagged with the channel that is active at that moment.

Each fault sets a sticky status bit for the channel involved. Setting that bit disables the channel at the same clock edge. Software clears status bits by writing ones.

The block also holds the channel enable bits, which software loads with a write strobe. It drives a single interrupt line. That line is the OR of every channel whose status bit is set and whose interrupt enable is high.

Top module: `dma_fault_track`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `err_sts`, `ch_en` and `irq` are all zero.
- R2: When `start_vld` is high, the transfer width `xfer_width` is decoded as 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. These require the low 0, 1, 2 and 3 address bits respectively to be zero. If `src_addr` or `dst_addr` breaks that rule, `err_sts[start_ch]` is set at the next clock edge. Aligned addresses set nothing.
- R3: A `tmo_err` pulse sets `err_sts[act_ch]` at the next clock edge.
- R4: A `slv_err` pulse sets `err_sts[act_ch]` at the next clock edge.
- R5: A `par_err` pulse sets `err_sts[act_ch]` only when `par_chk_en[act_ch]` and `periph_mode` are both high. Otherwise it has no effect on any output.
- R6: At the edge where a channel's status bit becomes set, that channel's `ch_en` bit becomes zero.
- R7: A status bit stays set until a cycle in which the matching `sts_clr` bit is 1 and no new fault hits that channel. Zero bits in `sts_clr` have no effect. A fault in the same cycle as a clear leaves the bit set.
- R8: `irq` is high exactly when some channel has both its `err_sts` bit and its `irq_en` bit set.
- R9: An `en_wr` pulse loads `en_wdata` into `ch_en`. Any channel whose status bit is set after that edge is forced to zero instead.
- R10: A fault tagged for one channel changes neither the status bit nor the enable bit of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_vld | input | 1 | Transfer start strobe |
| start_ch | input | CW | Channel that is starting |
| src_addr | input | AW | Source address of the starting transfer |
| dst_addr | input | AW | Destination address of the starting transfer |
| xfer_width | input | 2 | Transfer width code of the starting transfer |
| act_ch | input | CW | Channel owning the current bus activity |
| tmo_err | input | 1 | Bus timeout pulse |
| slv_err | input | 1 | Slave error pulse |
| par_err | input | 1 | Peripheral parity error pulse |
| periph_mode | input | 1 | Current transfer is in peripheral mode |
| par_chk_en | input | NCH | Per-channel parity check enable |
| irq_en | input | NCH | Per-channel interrupt enable |
| en_wr | input | 1 | Channel enable write strobe |
| en_wdata | input | NCH | Channel enable write data |
| sts_clr | input | NCH | Write-one-to-clear mask for status |
| ch_en | output | NCH | Channel enable bits |
| err_sts | output | NCH | Sticky per-channel error status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the fault pulses, start strobe and clear mask are driven to known values from reset onward. They also assume that `act_ch` and `start_ch` name a real channel whenever their strobes are high. The bench keeps every channel number inside the default channel count and holds every input at a defined value from time zero. It changes inputs only on the falling clock edge. Random cycles fire each fault class with low probability, so status bits both build up and get cleared. Directed cycles force same-cycle collisions between faults, clears and enable writes.

// File: rtl/dma_fault_track.sv
module dma_fault_track #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_vld,
  input  logic [CW-1:0]  start_ch,
  input  logic [AW-1:0]  src_addr,
  input  logic [AW-1:0]  dst_addr,
  input  logic [1:0]     xfer_width,
  input  logic [CW-1:0]  act_ch,
  input  logic           tmo_err,
  input  logic           slv_err,
  input  logic           par_err,
  input  logic           periph_mode,
  input  logic [NCH-1:0] par_chk_en,
  input  logic [NCH-1:0] irq_en,
  input  logic           en_wr,
  input  logic [NCH-1:0] en_wdata,
  input  logic [NCH-1:0] sts_clr,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] err_sts,
  output logic           irq
);

  logic [NCH-1:0] sts_q, en_q, err_hit, sts_d;
  logic [2:0]     amask;
  logic           misal, bus_hit;

  assign amask   = (3'b001 << xfer_width) - 3'b001;
  assign misal   = |((src_addr | dst_addr) & AW'(amask));
  assign bus_hit = tmo_err | slv_err | (par_err & par_chk_en[act_ch] & periph_mode);

  always_comb begin
    err_hit = '0;
    if (start_vld && misal) err_hit[start_ch] = 1'b1;
    if (bus_hit)            err_hit[act_ch]   = 1'b1;
  end

  assign sts_d = (sts_q & ~sts_clr) | err_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= (en_wr ? en_wdata : en_q) & ~sts_d;
    end
  end

  assign err_sts = sts_q;
  assign ch_en   = en_q;
  assign irq     = |(sts_q & irq_en);

  // R3
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> err_sts[$past(act_ch)]);

  // R2
  align_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vld && xfer_width != 2'd0 && (src_addr[0] || dst_addr[0])) |=> err_sts[$past(start_ch)]);

  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sts & ch_en) == '0);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_sts) & ~$past(sts_clr)) & ~err_sts) == '0);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (err_sts != '0));

endmodule

// File: tb/tb_dma_fault_track.sv
module tb_dma_fault_track;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int CW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_vld = 1'b0;
  logic [CW-1:0] start_ch = '0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [1:0] xfer_width = '0;
  logic [CW-1:0] act_ch = '0;
  logic tmo_err = 1'b0, slv_err = 1'b0, par_err = 1'b0, periph_mode = 1'b0;
  logic [NCH-1:0] par_chk_en = '0, irq_en = '0, en_wdata = '0, sts_clr = '0;
  logic en_wr = 1'b0;
  logic [NCH-1:0] ch_en, err_sts;
  logic irq;

  logic [NCH-1:0] e_sts = '0, e_en = '0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dma_fault_track #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_ch(start_ch),
    .src_addr(src_addr), .dst_addr(dst_addr), .xfer_width(xfer_width),
    .act_ch(act_ch), .tmo_err(tmo_err), .slv_err(slv_err), .par_err(par_err),
    .periph_mode(periph_mode), .par_chk_en(par_chk_en), .irq_en(irq_en),
    .en_wr(en_wr), .en_wdata(en_wdata), .sts_clr(sts_clr),
    .ch_en(ch_en), .err_sts(err_sts), .irq(irq));

  function automatic logic misal(input logic [AW-1:0] a, input logic [1:0] w);
    logic [AW-1:0] m;
    m = (AW'(1) << w) - AW'(1);
    return (a & m) != '0;
  endfunction

  function automatic logic [NCH-1:0] faults();
    logic [NCH-1:0] v;
    v = '0;
    if (start_vld && (misal(src_addr, xfer_width) || misal(dst_addr, xfer_width)))
      v[start_ch] = 1'b1;
    if (tmo_err || slv_err || (par_err && par_chk_en[act_ch] && periph_mode))
      v[act_ch] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    start_vld = 0; tmo_err = 0; slv_err = 0; par_err = 0; en_wr = 0; sts_clr = '0;
  endtask

  task automatic cyc(input string tag);
    logic [NCH-1:0] ns;
    ns = (e_sts & ~sts_clr) | faults();
    e_en = (en_wr ? en_wdata : e_en) & ~ns;
    e_sts = ns;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " sts"}, 32'(err_sts), 32'(e_sts));
    chk({tag, " en"}, 32'(ch_en), 32'(e_en));
    chk({tag, " irq R8"}, 32'(irq), 32'(|(e_sts & irq_en)));
    idle();
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset sts", 32'(err_sts), 0);
    chk("R1 reset en", 32'(ch_en), 0);
    chk("R1 reset irq", 32'(irq), 0);
    rst_n = 1;

    en_wr = 1; en_wdata = 4'hF; cyc("R9 load");
    // R2: each width, aligned then misaligned
    for (int w = 0; w < 4; w++) begin
      start_vld = 1; start_ch = CW'(w); xfer_width = 2'(w);
      src_addr = 32'h100; dst_addr = 32'h208; cyc("R2 aligned");
      start_vld = 1; start_ch = CW'(w); xfer_width = 2'(w);
      src_addr = 32'h100; dst_addr = 32'h200 | ((32'd1 << w) >> 1);
      cyc(w == 0 ? "R2 byte never misaligned" : "R2 misaligned R6 R10");
    end
    sts_clr = 4'hF; cyc("R7 clear all");
    en_wr = 1; en_wdata = 4'hF; cyc("R9 reload");
    act_ch = 2; tmo_err = 1; cyc("R3 timeout R6 R10");
    act_ch = 1; slv_err = 1; cyc("R4 slave R6");
    act_ch = 3; par_err = 1; periph_mode = 1; par_chk_en = 4'h0; cyc("R5 parity no pce");
    act_ch = 3; par_err = 1; periph_mode = 0; par_chk_en = 4'hF; cyc("R5 parity no periph");
    act_ch = 3; par_err = 1; periph_mode = 1; cyc("R5 parity counted");
    irq_en = 4'b0001; cyc("R8 irq masked");
    irq_en = 4'b0100; cyc("R8 irq on");
    sts_clr = 4'b0100; act_ch = 2; tmo_err = 1; cyc("R7 fault beats clear");
    sts_clr = 4'b0010; cyc("R7 single clear");
    en_wr = 1; en_wdata = 4'hF; cyc("R9 write blocked by status");
    sts_clr = 4'hF; cyc("R7 clear rest");
    en_wr = 1; en_wdata = 4'b1010; cyc("R9 write pattern");

    for (int i = 0; i < 2000; i++) begin
      start_vld = ($urandom % 4) == 0;
      start_ch = CW'($urandom);
      xfer_width = 2'($urandom);
      src_addr = $urandom & 32'hFFFF_FFF0 | (($urandom % 3 == 0) ? ($urandom & 32'h7) : 0);
      dst_addr = $urandom & 32'hFFFF_FFF0 | (($urandom % 3 == 0) ? ($urandom & 32'h7) : 0);
      act_ch = CW'($urandom);
      tmo_err = ($urandom % 12) == 0;
      slv_err = ($urandom % 12) == 0;
      par_err = ($urandom % 6) == 0;
      periph_mode = $urandom % 2;
      par_chk_en = NCH'($urandom);
      irq_en = NCH'($urandom);
      en_wr = ($urandom % 4) == 0;
      en_wdata = NCH'($urandom);
      sts_clr = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
      cyc("R2 R3 R4 R5 R7 R9 R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule